// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns two 16-bit register operands of a small 16-bit processor into a 23-bit physical address. The two operands are added into a 16-bit offset. The offset is then widened with upper address bits taken from one of three sources. If either operand is the program counter, a 7-bit code segment supplies the top bits. Otherwise the top bit of the offset picks one of two 8-bit data banks, and that bank fills bits 22:15.

The block owns the code-segment register, the saved copy of it that is kept on exception entry, and both data-bank bytes. A long jump reloads the segment, and exception entry saves it and clears it. The two bank bytes are written and read as one packed 16-bit word. A region decoder sorts each address into ROM, RAM, back-buffer video memory or reserved space. It produces the mirrored local address inside the region and flags accesses to reserved space. Address generation is combinational. The registers update on the rising clock edge.

Top module: `bank_addr_gen`

## Requirements
- R1: The offset is (opa_val + opb_val) modulo 2^16. Bits 14:0 of phys_addr always equal bits 14:0 of this offset.
- R2: When opa_is_pc or opb_is_pc is 1, phys_addr = {code_seg, offset}.
- R3: When neither operand is the program counter and offset bit 15 is 1, phys_addr = {high bank byte, offset[14:0]}.
- R4: When neither operand is the program counter and offset bit 15 is 0, phys_addr = {low bank byte, offset[14:0]}.
- R5: When bank_wr_en is 1 at a clock edge, the high bank byte is loaded from bank_wr_val[15:8] and the low bank byte from bank_wr_val[7:0]. From the next cycle, bank_rd returns {high, low} in the same layout.
- R6: When ljmp_en is 1 and exc_entry is 0 at a clock edge, code_seg is loaded from ljmp_seg_val[6:0], and bits 15:7 are ignored. When neither ljmp_en nor exc_entry is 1, code_seg holds its value.
- R7: When exc_entry is 1 at a clock edge, saved_seg takes the current code_seg and code_seg becomes 0. This happens even if ljmp_en is 1 in the same cycle.
- R8: The region output is encoded as follows.
  - 2'b00 is ROM, for 0x000000–0x3FFFFF. local_addr is phys_addr[21:0].
  - 2'b01 is RAM, for 0x400000–0x4FFFFF, mirrored every 128 KB. local_addr is phys_addr[16:0] zero-extended.
  - 2'b10 is video back buffer, for 0x700000–0x7FFFFF, mirrored every 64 KB. local_addr is phys_addr[15:0] zero-extended.
  - 2'b11 is reserved, for 0x500000–0x6FFFFF. local_addr is 0.
- R9: For a reserved-region address, decode_err is 1 and rd_data is 0xFFFF. Otherwise decode_err is 0 and rd_data equals mem_rd_data.
- R10: Reset (rst high at a clock edge) clears code_seg, saved_seg and both bank bytes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa_val | input | 16 | First operand value |
| opb_val | input | 16 | Second operand value |
| opa_is_pc | input | 1 | First operand is the program counter |
| opb_is_pc | input | 1 | Second operand is the program counter |
| ljmp_en | input | 1 | Long jump: load code segment |
| ljmp_seg_val | input | 16 | Register value whose low 7 bits give the new segment |
| exc_entry | input | 1 | Exception entry: save and clear segment |
| bank_wr_en | input | 1 | Write packed data-bank word |
| bank_wr_val | input | 16 | Packed bank word {high, low} |
| mem_rd_data | input | 16 | Read data returned by the memory system |
| phys_addr | output | 23 | Generated physical address |
| region | output | 2 | Region code (see R8) |
| local_addr | output | 22 | Mirrored address within the region |
| decode_err | output | 1 | Access falls in reserved space |
| rd_data | output | 16 | Read data after reserved-space override |
| code_seg | output | 7 | Current code segment |
| saved_seg | output | 7 | Code segment saved at exception entry |
| bank_rd | output | 16 | Packed data-bank word {high, low} |

## Verification
The address path is driven with several operand pairs, each chosen to separate two things:
- program-counter forms, on either operand, against data forms;
- offsets with bit 15 set against offsets with it clear, so that a swapped bank is visible;
- a sum that overflows 16 bits, which shows that the carry is dropped rather than leaking into the bank bits.

Bank values are picked so the results land in every region, including a mirrored RAM copy, both halves of video memory and reserved space. Reserved space is also checked to force all ones over a non-trivial memory word. The segment register is exercised by a long jump whose upper operand bits are set, by exception entry, by a long jump and an exception in the same cycle, and by idle cycles in which it must hold.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  typedef enum logic [1:0] {
    RGN_ROM  = 2'b00,
    RGN_RAM  = 2'b01,
    RGN_VRAM = 2'b10,
    RGN_RSVD = 2'b11
  } region_t;
endpackage

// File: rtl/seg_bank_regs.sv
module seg_bank_regs #(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 7,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ljmp_en,
  input  logic [DATA_W-1:0] ljmp_seg_val,
  input  logic              exc_entry,
  input  logic              bank_wr_en,
  input  logic [DATA_W-1:0] bank_wr_val,
  output logic [SEG_W-1:0]  code_seg,
  output logic [SEG_W-1:0]  saved_seg,
  output logic [BANK_W-1:0] bank_hi,
  output logic [BANK_W-1:0] bank_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_seg  <= '0;
      saved_seg <= '0;
    end else if (exc_entry) begin
      saved_seg <= code_seg;
      code_seg  <= '0;
    end else if (ljmp_en) begin
      code_seg <= ljmp_seg_val[SEG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_hi <= '0;
      bank_lo <= '0;
    end else if (bank_wr_en) begin
      bank_hi <= bank_wr_val[2*BANK_W-1:BANK_W];
      bank_lo <= bank_wr_val[BANK_W-1:0];
    end
  end

  // R7: exception saves the segment and clears it
  p_exc_save_r7: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> (code_seg == '0) && (saved_seg == $past(code_seg)));
  // R6: long jump loads the low segment bits
  p_ljmp_load_r6: assert property (@(posedge clk) disable iff (rst)
    (ljmp_en && !exc_entry) |=> code_seg == $past(ljmp_seg_val[SEG_W-1:0]));
  // R6: the segment holds when idle
  p_seg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ljmp_en && !exc_entry) |=> $stable(code_seg));
endmodule

// File: rtl/offset_extend.sv
module offset_extend #(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 7,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 23
) (
  input  logic [DATA_W-1:0] opa_val,
  input  logic [DATA_W-1:0] opb_val,
  input  logic              use_seg,
  input  logic [SEG_W-1:0]  code_seg,
  input  logic [BANK_W-1:0] bank_hi,
  input  logic [BANK_W-1:0] bank_lo,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int LOW_W = DATA_W - 1;
  logic [DATA_W-1:0] offset;
  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    offset   = opa_val + opb_val;
    bank_sel = offset[DATA_W-1] ? bank_hi : bank_lo;
    if (use_seg) phys_addr = {code_seg, offset};
    else         phys_addr = {bank_sel, offset[LOW_W-1:0]};
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import bank_addr_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int LOC_W  = 22,
  parameter int RAM_W  = 17,
  parameter int VRAM_W = 16
) (
  input  logic [ADDR_W-1:0] phys_addr,
  output region_t           region,
  output logic [LOC_W-1:0]  local_addr
);
  localparam int TOP = ADDR_W - 1;
  always_comb begin
    local_addr = '0;
    if (!phys_addr[TOP]) begin
      region     = RGN_ROM;
      local_addr = phys_addr[LOC_W-1:0];
    end else begin
      case (phys_addr[TOP-1:TOP-2])
        2'b00: begin
          region     = RGN_RAM;
          local_addr = {{(LOC_W-RAM_W){1'b0}}, phys_addr[RAM_W-1:0]};
        end
        2'b11: begin
          region     = RGN_VRAM;
          local_addr = {{(LOC_W-VRAM_W){1'b0}}, phys_addr[VRAM_W-1:0]};
        end
        default: region = RGN_RSVD;
      endcase
    end
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bank_addr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 7,
  parameter int BANK_W = 8,
  parameter int RAM_W  = 17,
  parameter int VRAM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         opa_val,
  input  logic [DATA_W-1:0]         opb_val,
  input  logic                      opa_is_pc,
  input  logic                      opb_is_pc,
  input  logic                      ljmp_en,
  input  logic [DATA_W-1:0]         ljmp_seg_val,
  input  logic                      exc_entry,
  input  logic                      bank_wr_en,
  input  logic [DATA_W-1:0]         bank_wr_val,
  input  logic [DATA_W-1:0]         mem_rd_data,
  output logic [SEG_W+DATA_W-1:0]   phys_addr,
  output logic [1:0]                region,
  output logic [SEG_W+DATA_W-2:0]   local_addr,
  output logic                      decode_err,
  output logic [DATA_W-1:0]         rd_data,
  output logic [SEG_W-1:0]          code_seg,
  output logic [SEG_W-1:0]          saved_seg,
  output logic [2*BANK_W-1:0]       bank_rd
);
  localparam int ADDR_W = SEG_W + DATA_W;
  localparam int LOC_W  = ADDR_W - 1;

  logic [BANK_W-1:0] bank_hi, bank_lo;
  region_t           rgn;
  logic              use_seg;

  assign use_seg = opa_is_pc | opb_is_pc;

  seg_bank_regs #(.DATA_W(DATA_W), .SEG_W(SEG_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .ljmp_en(ljmp_en), .ljmp_seg_val(ljmp_seg_val),
    .exc_entry(exc_entry), .bank_wr_en(bank_wr_en), .bank_wr_val(bank_wr_val),
    .code_seg(code_seg), .saved_seg(saved_seg), .bank_hi(bank_hi), .bank_lo(bank_lo)
  );

  offset_extend #(.DATA_W(DATA_W), .SEG_W(SEG_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_ext (
    .opa_val(opa_val), .opb_val(opb_val), .use_seg(use_seg), .code_seg(code_seg),
    .bank_hi(bank_hi), .bank_lo(bank_lo), .phys_addr(phys_addr)
  );

  region_decode #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .RAM_W(RAM_W), .VRAM_W(VRAM_W)) u_dec (
    .phys_addr(phys_addr), .region(rgn), .local_addr(local_addr)
  );

  assign region     = rgn;
  assign decode_err = (rgn == RGN_RSVD);
  assign rd_data    = decode_err ? '1 : mem_rd_data;
  assign bank_rd    = {bank_hi, bank_lo};

  logic [DATA_W-1:0] chk_sum;
  assign chk_sum = opa_val + opb_val;

  // R1: low offset bits pass through unchanged
  p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
    phys_addr[DATA_W-2:0] == chk_sum[DATA_W-2:0]);
  // R2: program-counter form uses the code segment
  p_pc_seg_r2: assert property (@(posedge clk) disable iff (rst)
    use_seg |-> phys_addr[ADDR_W-1:DATA_W] == code_seg);
  // R5: bank word readback after write
  p_bank_wr_r5: assert property (@(posedge clk) disable iff (rst)
    bank_wr_en |=> bank_rd == $past(bank_wr_val));
  // R9: reserved access reads all ones
  p_rsvd_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (phys_addr[ADDR_W-1:ADDR_W-3] == 3'b101 || phys_addr[ADDR_W-1:ADDR_W-3] == 3'b110)
      |-> (decode_err && rd_data == '1));
  // R8: RAM mirror leaves upper local bits clear
  p_ram_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    (region == 2'b01) |-> local_addr[LOC_W-1:RAM_W] == '0);
endmodule

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic [15:0] opa_val = '0, opb_val = '0, ljmp_seg_val = '0, bank_wr_val = '0, mem_rd_data = '0;
  logic        opa_is_pc = 0, opb_is_pc = 0, ljmp_en = 0, exc_entry = 0, bank_wr_en = 0;
  logic [22:0] phys_addr;
  logic [1:0]  region;
  logic [21:0] local_addr;
  logic        decode_err;
  logic [15:0] rd_data, bank_rd;
  logic [6:0]  code_seg, saved_seg;

  int total = 0, bad = 0;
  logic [7:0] m_hi = 0, m_lo = 0;
  logic [6:0] m_seg = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_addr_gen uut (
    .clk(clk), .rst(rst), .opa_val(opa_val), .opb_val(opb_val),
    .opa_is_pc(opa_is_pc), .opb_is_pc(opb_is_pc), .ljmp_en(ljmp_en),
    .ljmp_seg_val(ljmp_seg_val), .exc_entry(exc_entry), .bank_wr_en(bank_wr_en),
    .bank_wr_val(bank_wr_val), .mem_rd_data(mem_rd_data), .phys_addr(phys_addr),
    .region(region), .local_addr(local_addr), .decode_err(decode_err),
    .rd_data(rd_data), .code_seg(code_seg), .saved_seg(saved_seg), .bank_rd(bank_rd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // clock edge then settle away from the edge
  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic write_banks(logic [15:0] v);
    bank_wr_val = v; bank_wr_en = 1;
    tick();
    bank_wr_en = 0;
    m_hi = v[15:8]; m_lo = v[7:0];
    check("R5 bank_rd", {16'h0, bank_rd}, {16'h0, v});
  endtask

  // drive an access and check address, region, local and read data
  task automatic access(string req, logic [15:0] a, logic [15:0] b, logic apc, logic bpc);
    logic [15:0] s;
    logic [22:0] e;
    logic [1:0]  er;
    logic [21:0] el;
    opa_val = a; opb_val = b; opa_is_pc = apc; opb_is_pc = bpc;
    mem_rd_data = 16'h5A3C;
    #1;
    s = a + b;
    if (apc || bpc)  e = {m_seg, s};
    else if (s[15])  e = {m_hi, s[14:0]};
    else             e = {m_lo, s[14:0]};
    if (!e[22])                  begin er = 2'b00; el = e[21:0]; end
    else if (e[21:20] == 2'b00)  begin er = 2'b01; el = {5'b0, e[16:0]}; end
    else if (e[21:20] == 2'b11)  begin er = 2'b10; el = {6'b0, e[15:0]}; end
    else                         begin er = 2'b11; el = '0; end
    check({req, " addr"}, {9'h0, phys_addr}, {9'h0, e});
    check("R8 region", {30'h0, region}, {30'h0, er});
    check("R8 local", {10'h0, local_addr}, {10'h0, el});
    check("R9 err", {31'h0, decode_err}, {31'h0, er == 2'b11});
    check("R9 rd_data", {16'h0, rd_data}, {16'h0, (er == 2'b11) ? 16'hFFFF : 16'h5A3C});
    opa_is_pc = 0; opb_is_pc = 0;
  endtask

  task automatic t_reset();
    check("R10 code_seg", {25'h0, code_seg}, 32'h0);
    check("R10 saved_seg", {25'h0, saved_seg}, 32'h0);
    check("R10 bank_rd", {16'h0, bank_rd}, 32'h0);
    access("R10/R4", 16'h1234, 16'h0000, 0, 0);
  endtask

  task automatic t_banks();
    write_banks(16'hA53C);
    access("R3 hi bank", 16'h9000, 16'h0123, 0, 0);
    access("R4 lo bank", 16'h0080, 16'h0080, 0, 0);
    access("R1 wrap", 16'hFFFF, 16'h0002, 0, 0);
    access("R1 carry into b15", 16'h7FFF, 16'h0001, 0, 0);
  endtask

  task automatic t_regions();
    write_banks(16'h8C80);
    access("R8 ram base", 16'h1000, 16'h0234, 0, 0);
    access("R8 ram mirror", 16'h8000, 16'h0005, 0, 0);
    write_banks(16'hFFE0);
    access("R8 vram hi", 16'hAB00, 16'h00CD, 0, 0);
    access("R8 vram lo", 16'h1200, 16'h0034, 0, 0);
  endtask

  task automatic t_ljmp();
    ljmp_seg_val = 16'hFF85; ljmp_en = 1;
    tick();
    ljmp_en = 0; m_seg = 7'h05;
    check("R6 ljmp seg", {25'h0, code_seg}, 32'h05);
    access("R2 pc on a", 16'h8000, 16'h0010, 1, 0);
    access("R2 pc on b", 16'h0004, 16'hF000, 0, 1);
    tick(); tick();
    check("R6 hold", {25'h0, code_seg}, 32'h05);
  endtask

  task automatic t_exc();
    exc_entry = 1;
    tick();
    exc_entry = 0; m_seg = 0;
    check("R7 saved", {25'h0, saved_seg}, 32'h05);
    check("R7 cleared", {25'h0, code_seg}, 32'h0);
    ljmp_seg_val = 16'h0033; ljmp_en = 1;
    tick();
    ljmp_en = 0; m_seg = 7'h33;
    check("R6 reload", {25'h0, code_seg}, 32'h33);
    ljmp_seg_val = 16'h0011; ljmp_en = 1; exc_entry = 1;
    tick();
    ljmp_en = 0; exc_entry = 0; m_seg = 0;
    check("R7 wins over ljmp", {25'h0, code_seg}, 32'h0);
    check("R7 saved 33", {25'h0, saved_seg}, 32'h33);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #(CLK_P/4) rst = 0;
        t_reset();
        t_banks();
        t_regions();
        t_ljmp();
        t_exc();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule